// File: doc/BRIEF.md
# Run-time selectable strength BCH check-bit encoder

The block produces the check bits of a systematic binary BCH code one byte per clock. The correction strength `t` is picked for each codeword at run time, within the range `T_MIN..T_MAX`. A single remainder register sized for `T_MAX` serves every strength. Data bytes enter through a valid/ready handshake and reach the output unchanged in the same cycle. Meanwhile the remainder register divides them by the generator polynomial for the chosen `t`. Once `K_BYTES` data bytes have been accepted, the block emits the `M*t` check bits as whole bytes, most significant first. The output then returns to the data phase for the next codeword.

The generator polynomials come in as a constant parameter table with one entry per strength. Entry `t` is the product of the minimal polynomials of alpha, alpha^3, ..., alpha^(2t-1) over GF(2^M), written without its leading term. The default build uses GF(32), strengths 1 to 3 and a 2-byte message. This is a shortened code small enough for a bit-exact reference in the bench.

Top module: `bch_sel_enc`

## Requirements
- R1: After reset the block is in the data phase: `out_valid` is 0 while `in_valid` is 0, `in_ready` equals `out_ready`, and `out_last` is 0.
- R2: In the data phase, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, `out_data` equals `in_data` whenever `in_valid` is 1, and `out_last` stays 0. A byte is accepted on a clock edge where `in_valid` and `out_ready` are both 1.
- R3: After the `K_BYTES`-th data byte is accepted, the block enters the parity phase. In this phase `in_ready` is 0 and `out_valid` is 1 for exactly ceil(`M*t`/8) accepted output bytes. Any `in_valid`/`in_data` presented during this phase has no effect.
- R4: The check bits are the remainder of x^(M*t)·d(x) divided by g_t(x), where d(x) takes the first data byte's bit 7 as its highest-degree coefficient. The remainder is sent highest degree first, packed from bit 7 downward. The unused low bits of the last byte are 0.
- R5: `out_last` is 1 only on the final check byte of a codeword, never in the data phase.
- R6: `in_tsel` is sampled when the first data byte is accepted. Its value on later data bytes and during the parity phase does not change the check bits or their count.
- R7: A sampled `in_tsel` below `T_MIN` acts as `T_MIN`; above `T_MAX` it acts as `T_MAX`.
- R8: While `out_ready` is 0, no byte is consumed. A pending check byte stays on `out_data` with `out_valid` high until accepted, and in the data phase `in_ready` is 0.
- R9: Each codeword starts from an empty remainder, so back-to-back codewords are encoded independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Data byte can be taken |
| in_data | input | 8 | Data byte |
| in_tsel | input | TSW | Requested strength, sampled on the first byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Data byte or check byte |
| out_last | output | 1 | Final check byte of the codeword |

## Verification
The properties assume that a sender keeps `in_valid` high and `in_data` steady until its byte is accepted. They also assume that the downstream side only ever stalls the output, never retracts a byte it took. The stimulus keeps a pending byte unchanged until the handshake completes. It draws gaps and stalls at random percentages and raises `out_ready` often enough for every codeword to finish. Strength requests include values outside `T_MIN..T_MAX`. Random strength values are driven on every cycle after the first byte to show they are ignored.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_PAR  = 1'b1
    } phase_e;

    // number of whole bytes needed for m*t check bits
    function automatic int par_bytes(input int m, input int t);
        return (m * t + 7) / 8;
    endfunction

endpackage

// File: rtl/bch_poly_sel.sv
module bch_poly_sel #(
    parameter int M      = 5,
    parameter int T_MAX  = 3,
    parameter int PW     = M * T_MAX,
    parameter int TW     = $clog2(T_MAX + 1),
    parameter logic [T_MAX*PW-1:0] GEN_LO = {15'h0FAF, 15'h0369, 15'h0005}
) (
    input  logic [TW-1:0] t_sel,
    output logic [PW-1:0] g_al
);

    logic [PW-1:0] cand [T_MAX];

    // each generator is left aligned so the feedback tap is always the MSB
    for (genvar gi = 0; gi < T_MAX; gi++) begin : g_ent
        localparam int SH = PW - M * (gi + 1);
        assign cand[gi] = GEN_LO[gi*PW +: PW] << SH;
    end

    always_comb begin
        g_al = '0;
        for (int i = 0; i < T_MAX; i++) begin
            if (int'(t_sel) == i + 1) g_al = cand[i];
        end
    end

endmodule

// File: rtl/bch_lfsr.sv
module bch_lfsr #(
    parameter int PW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          absorb,
    input  logic          drain,
    input  logic [7:0]    din,
    input  logic [PW-1:0] g_al,
    output logic [7:0]    top_byte
);

    logic [PW-1:0] r_d, r_q;
    logic [PW-1:0] acc;
    logic          fb;

    always_comb begin
        r_d = r_q;
        acc = r_q;
        fb  = 1'b0;
        if (clr) begin
            r_d = '0;
        end else if (absorb) begin
            for (int i = 0; i < 8; i++) begin
                fb  = din[7-i] ^ acc[PW-1];
                acc = {acc[PW-2:0], 1'b0} ^ (fb ? g_al : '0);
            end
            r_d = acc;
        end else if (drain) begin
            r_d = r_q << 8;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign top_byte = r_q[PW-1 -: 8];

endmodule

// File: rtl/bch_enc_ctrl.sv
module bch_enc_ctrl
    import bch_enc_pkg::*;
#(
    parameter int M       = 5,
    parameter int T_MIN   = 1,
    parameter int T_MAX   = 3,
    parameter int K_BYTES = 2,
    parameter int TSW     = 4,
    parameter int TW      = $clog2(T_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [TSW-1:0] in_tsel,
    input  logic           out_ready,
    output logic           in_ready,
    output logic           out_valid,
    output logic           out_last,
    output logic           sel_par,
    output logic           absorb,
    output logic           drain,
    output logic           clr,
    output logic [TW-1:0]  t_eff,
    output logic [TW-1:0]  t_hold
);

    localparam int NPB_MAX = par_bytes(M, T_MAX);
    localparam int CNT_MAX = (K_BYTES > NPB_MAX) ? K_BYTES : NPB_MAX;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [TW-1:0] t;
    } st_t;

    st_t           s_d, s_q;
    logic [TW-1:0] t_in;
    logic [CW-1:0] last_idx;

    always_comb begin
        if (int'(in_tsel) < T_MIN)      t_in = TW'(T_MIN);
        else if (int'(in_tsel) > T_MAX) t_in = TW'(T_MAX);
        else                            t_in = in_tsel[TW-1:0];

        last_idx  = CW'(par_bytes(M, int'(s_q.t)) - 1);
        s_d       = s_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        sel_par   = 1'b0;
        absorb    = 1'b0;
        drain     = 1'b0;
        clr       = 1'b0;
        t_eff     = s_q.t;

        if (s_q.phase == PH_DATA) begin
            in_ready  = out_ready;
            out_valid = in_valid;
            if (s_q.cnt == '0) t_eff = t_in;
            if (in_valid && out_ready) begin
                absorb = 1'b1;
                if (s_q.cnt == '0) s_d.t = t_in;
                if (s_q.cnt == CW'(K_BYTES - 1)) begin
                    s_d.phase = PH_PAR;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else begin
            sel_par   = 1'b1;
            out_valid = 1'b1;
            out_last  = (s_q.cnt == last_idx);
            if (out_ready) begin
                if (out_last) begin
                    clr       = 1'b1;
                    s_d.phase = PH_DATA;
                    s_d.cnt   = '0;
                end else begin
                    drain   = 1'b1;
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_DATA;
            s_q.cnt   <= '0;
            s_q.t     <= TW'(T_MIN);
        end else begin
            s_q <= s_d;
        end
    end

    assign t_hold = s_q.t;

endmodule

// File: rtl/bch_sel_enc.sv
module bch_sel_enc #(
    parameter int M       = 5,
    parameter int T_MIN   = 1,
    parameter int T_MAX   = 3,
    parameter int K_BYTES = 2,
    parameter int TSW     = 4,
    parameter logic [T_MAX*M*T_MAX-1:0] GEN_LO = {15'h0FAF, 15'h0369, 15'h0005}
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [7:0]     in_data,
    input  logic [TSW-1:0] in_tsel,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [7:0]     out_data,
    output logic           out_last
);

    localparam int PW = M * T_MAX;
    localparam int TW = $clog2(T_MAX + 1);

    logic          sel_par, absorb, drain, clr;
    logic [TW-1:0] t_eff, t_hold;
    logic [PW-1:0] g_al;
    logic [7:0]    par_byte;

    bch_enc_ctrl #(
        .M(M), .T_MIN(T_MIN), .T_MAX(T_MAX), .K_BYTES(K_BYTES), .TSW(TSW), .TW(TW)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_tsel  (in_tsel),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .sel_par  (sel_par),
        .absorb   (absorb),
        .drain    (drain),
        .clr      (clr),
        .t_eff    (t_eff),
        .t_hold   (t_hold)
    );

    bch_poly_sel #(
        .M(M), .T_MAX(T_MAX), .PW(PW), .TW(TW), .GEN_LO(GEN_LO)
    ) i_psel (
        .t_sel(t_eff),
        .g_al (g_al)
    );

    bch_lfsr #(
        .PW(PW)
    ) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .absorb  (absorb),
        .drain   (drain),
        .din     (in_data),
        .g_al    (g_al),
        .top_byte(par_byte)
    );

    assign out_data = sel_par ? par_byte : in_data;

endmodule

// File: rtl/bch_sel_enc_chk.sv
module bch_sel_enc_chk
    import bch_enc_pkg::*;
#(
    parameter int M  = 5,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [7:0]    out_data,
    input logic          par,
    input logic [TW-1:0] t_hold
);

    int beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      beats <= 0;
        else if (par && out_ready)       beats <= out_last ? 0 : beats + 1;
    end

    // R3: no data is taken while check bytes are leaving
    a_r3_no_accept_in_parity: assert property (@(posedge clk) disable iff (!rst_n)
        par |-> !in_ready);

    // R3: the last check byte closes exactly ceil(M*t/8) beats
    a_r3_parity_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && out_ready) |-> (beats == par_bytes(M, int'(t_hold)) - 1));

    // R5: the last flag only rides on a valid check byte
    a_r5_last_in_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && par));

    // R8: a stalled check byte is held
    a_r8_hold_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (par && !out_ready) |=> (par && out_valid && $stable(out_data)));

    // R6: the strength is frozen through the parity phase
    a_r6_t_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (par && !(out_last && out_ready)) |=> $stable(t_hold));

endmodule

bind bch_sel_enc bch_sel_enc_chk #(.M(M), .TW(TW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_last (out_last),
    .out_data (out_data),
    .par      (sel_par),
    .t_hold   (t_hold)
);

// File: tb/test_bch_sel_enc.sv
module test_bch_sel_enc;

    localparam int CLK_PERIOD = 10;
    localparam int M       = 5;
    localparam int T_MIN   = 1;
    localparam int T_MAX   = 3;
    localparam int K_BYTES = 2;
    localparam int TSW     = 4;
    localparam int KB      = K_BYTES * 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic           in_ready;
    logic [7:0]     in_data;
    logic [TSW-1:0] in_tsel;
    logic           out_valid;
    logic           out_ready;
    logic [7:0]     out_data;
    logic           out_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bch_sel_enc #(
        .M(M), .T_MIN(T_MIN), .T_MAX(T_MAX), .K_BYTES(K_BYTES), .TSW(TSW)
    ) i_bch_sel_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_tsel(in_tsel), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint gen_full(input int t);
        case (t)
            1:       return 64'h25;
            2:       return 64'h769;
            default: return 64'h8FAF;
        endcase
    endfunction

    function automatic int clampt(input int v);
        if (v < T_MIN) return T_MIN;
        if (v > T_MAX) return T_MAX;
        return v;
    endfunction

    // long division of the shifted message, result left aligned in whole bytes
    function automatic longint ref_parity(input logic [KB-1:0] msg, input int t);
        int     deg = M * t;
        int     nb  = (deg + 7) / 8;
        longint g   = gen_full(t);
        longint p   = longint'(msg) << deg;
        longint rem;
        for (int i = KB + deg - 1; i >= deg; i--) begin
            if (p[i]) p = p ^ (g << (i - deg));
        end
        rem = p & ((64'd1 << deg) - 1);
        return rem << (nb * 8 - deg);
    endfunction

    task automatic run_cw(input logic [KB-1:0] msg, input int tsel_first,
                          input int ready_pct, input int gap_pct, input string tag);
        int     t   = clampt(tsel_first);
        int     nb  = (M * t + 7) / 8;
        longint par = ref_parity(msg, t);
        int     idx = 0;
        int     j   = 0;
        bit     pending = 1'b0;
        logic [7:0] expb;
        while (idx < K_BYTES) begin
            @(negedge clk);
            out_ready = (($urandom % 100) < ready_pct);
            if (!pending) pending = (($urandom % 100) >= gap_pct);
            in_valid = pending;
            in_data  = msg[(K_BYTES - 1 - idx) * 8 +: 8];
            in_tsel  = (idx == 0) ? TSW'(tsel_first) : TSW'($urandom % 16);
            #1;
            chk(out_valid == in_valid, "R2 valid passthrough", out_valid, in_valid);
            chk(in_ready == out_ready, "R2/R8 ready follows", in_ready, out_ready);
            if (in_valid) chk(out_data == in_data, "R2 data passthrough", out_data, in_data);
            chk(out_last == 1'b0, "R5 no last in data", out_last, 0);
            if (in_valid && out_ready) begin
                idx++;
                pending = 1'b0;
            end
        end
        while (j < nb) begin
            @(negedge clk);
            out_ready = (($urandom % 100) < ready_pct);
            in_valid  = $urandom % 2;
            in_data   = 8'($urandom);
            in_tsel   = TSW'($urandom % 16);
            #1;
            expb = 8'(par >> (8 * (nb - 1 - j)));
            chk(in_ready == 1'b0, "R3 ready low in parity", in_ready, 0);
            chk(out_valid == 1'b1, "R3/R8 valid in parity", out_valid, 1);
            chk(out_data == expb, {"R4 check byte ", tag}, out_data, expb);
            chk(out_last == (j == nb - 1), "R5 last flag", out_last, (j == nb - 1));
            if (out_ready) j++;
        end
    endtask

    initial begin
        void'($urandom(32'd24680));
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_tsel   = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_last == 1'b0, "R1 reset out_last", out_last, 0);

        // directed corners
        run_cw(16'h0000, 1, 100, 0, "R4 zero t1");
        run_cw(16'h0000, 3, 100, 0, "R4 zero t3");
        run_cw(16'hFFFF, 3, 100, 0, "R4 ones t3");
        run_cw(16'h0001, 2, 100, 0, "R4 lsb t2");
        run_cw(16'h8000, 2, 100, 0, "R4 msb t2");
        run_cw(16'hA5C3, 0, 100, 0, "R7 low clamp");
        run_cw(16'h3C5A, 15, 100, 0, "R7 high clamp");
        run_cw(16'h1234, 1, 60, 20, "R6 later tsel ignored");
        run_cw(16'hBEEF, 2, 30, 40, "R8 stalls");
        run_cw(16'h0F0F, 3, 100, 0, "R9 back to back");
        run_cw(16'h0F0F, 1, 100, 0, "R9 back to back");

        // random mix
        for (int n = 0; n < 120; n++) begin
            run_cw(16'($urandom), int'($urandom % 16), 40 + int'($urandom % 61),
                   int'($urandom % 50), "R4 random");
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule